// File: doc/BRIEF.md
# Self-Calibrating Window Watchdog

This block supervises a host processor through a periodic kick on `wdi`. Every watchdog frame begins with a closed window, in which a kick is not allowed, and continues with an open window, in which a kick is expected. A rising kick edge inside the open window ends the frame and starts a new one. A rising edge inside the closed window is an early fault. No rising edge by the end of the open window is a late fault. Either fault is held on the fault output for a fixed number of cycles. After that the next frame begins.

The base time unit comes from a single measurement of an external timing element. After reset is released, the block drives `chg` until the threshold comparator input `cmp` reads high. It then drives `dis` until `cmp` reads low again. It counts every clock cycle spent in these two phases and stores the result as the calibration count. The element is then left alone until the next reset, so supervision runs without gaps. The closed window is the stored count scaled by a ratio that the 2-bit `set` input selects (8:4:1). One code can instead switch supervision off. The open window is a fixed multiple of the stored count.

A build parameter chooses the fault pin. The fault goes either to a dedicated watchdog output or to the reset-request output.

Top module: `wdog_cal`

## Requirements
- R1: After reset release, `chg` is high from the second clock edge until `cmp` is seen high at a clock edge. `dis` is then high until `cmp` is seen low at a clock edge. Neither is ever high again before the next reset, and the two are never high together.
- R2: The calibration count equals the number of clock edges with `chg` high plus those with `dis` high. It saturates at 2^CNT_W-1.
- R3: The closed window starts in the cycle after `dis` falls. Its length in cycles is 8×count for `set` 00 or 01, 4×count for `set` 10 and 1×count for `set` 11.
- R4: The open window follows directly and lasts OPEN_MULT×count cycles. A rising `wdi` edge judged inside it starts a new closed window in the next cycle, with no fault.
- R5: `wdi` passes through a two-flop synchronizer. A level change driven before clock edge k+1 is judged against the phase in force between edges k+2 and k+3. A rising edge judged inside the closed window (including its last cycle) raises the fault after edge k+3.
- R6: If no rising edge is judged inside the open window, the fault rises in the first cycle after it ends.
- R7: A fault stays high for exactly HOLD cycles, ignoring `wdi`. A new closed window then starts.
- R8: Only rising `wdi` edges count. A falling edge in a closed window raises no fault.
- R9: With SET01_OFF=1, `set`=01 disables supervision, and `wdi` then never causes a fault. Leaving code 01 starts a fresh closed window in the next cycle.
- R10: With HAS_WDO=1 a fault drives `wdo` and `rst_req` stays low. With HAS_WDO=0 a fault drives `rst_req` and `wdo` stays low.
- R11: While `rst_n` is low, all outputs are low. Every reset release triggers a new calibration, and its count replaces the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wdi | input | 1 | Host kick, asynchronous |
| set | input | 2 | Window scaling / disable code |
| cmp | input | 1 | Threshold comparator of the timing element |
| chg | output | 1 | Charge control for the timing element |
| dis | output | 1 | Discharge control for the timing element |
| wdo | output | 1 | Watchdog fault (HAS_WDO=1) |
| rst_req | output | 1 | Reset request carrying the fault (HAS_WDO=0) |

## Verification
The cycle-by-cycle checks cover these rules:
- `chg` and `dis` are exclusive, and neither comes back after calibration.
- The stored count never decreases.
- A judged rising edge in the closed window is followed by a fault.
- A fault is never longer or shorter than HOLD.
- The two fault outputs are never high together, and a disabled watchdog raises no new fault.

The exact window lengths for each `set` code need the bench's directed boundary scenarios, as do the saturated count, the synchronizer latency, edges ignored during a fault, and recalibration after a second reset. The kicks at the last closed cycle and the first open cycle pin each length to the cycle.

// File: rtl/wdog_cal.sv
`timescale 1ns/1ps
module wdog_cal #(
  parameter int CNT_W     = 10,
  parameter int OPEN_MULT = 4,
  parameter int HOLD      = 6,
  parameter bit HAS_WDO   = 1'b1,
  parameter bit SET01_OFF = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wdi,
  input  logic [1:0] set,
  input  logic       cmp,
  output logic       chg,
  output logic       dis,
  output logic       wdo,
  output logic       rst_req
);
  localparam int TW = CNT_W + 3 + $clog2(OPEN_MULT + 1);
  localparam logic [TW-1:0] OPEN_K    = TW'(OPEN_MULT);
  localparam logic [TW-1:0] HOLD_LAST = TW'(HOLD - 1);

  typedef enum logic [2:0] {S_INIT, S_CHG, S_DIS, S_OFF, S_CLOSED, S_OPEN, S_FAULT} st_t;

  st_t             st;
  logic [CNT_W-1:0] cal;
  logic [TW-1:0]   tmr, cal_w, close_len, open_len;
  logic [2:0]      sync;
  logic            rise, off, flt, in_closed, last_c, last_o, last_h;

  assign rise      = sync[1] & ~sync[2];
  assign off       = SET01_OFF && (set == 2'b01);
  assign cal_w     = TW'(cal);
  assign close_len = (set == 2'b11) ? cal_w : (set == 2'b10) ? (cal_w << 2) : (cal_w << 3);
  assign open_len  = cal_w * OPEN_K;
  assign last_c    = (tmr == close_len - 1'b1);
  assign last_o    = (tmr == open_len - 1'b1);
  assign last_h    = (tmr == HOLD_LAST);
  assign in_closed = (st == S_CLOSED);
  assign flt       = (st == S_FAULT);
  assign chg       = (st == S_CHG);
  assign dis       = (st == S_DIS);
  assign wdo       = HAS_WDO & flt;
  assign rst_req   = ~HAS_WDO & flt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_INIT;
      cal  <= '0;
      tmr  <= '0;
      sync <= '0;
    end else begin
      sync <= {sync[1:0], wdi};
      case (st)
        S_INIT: st <= S_CHG;
        S_CHG: begin
          if (!(&cal)) cal <= cal + 1'b1;
          if (cmp) st <= S_DIS;
        end
        S_DIS: begin
          if (!(&cal)) cal <= cal + 1'b1;
          if (!cmp) begin
            st  <= off ? S_OFF : S_CLOSED;
            tmr <= '0;
          end
        end
        S_OFF: begin
          tmr <= '0;
          if (!off) st <= S_CLOSED;
        end
        S_CLOSED: begin
          if (off) begin
            st <= S_OFF;
          end else if (rise) begin
            st  <= S_FAULT;
            tmr <= '0;
          end else if (last_c) begin
            st  <= S_OPEN;
            tmr <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_OPEN: begin
          if (off) begin
            st <= S_OFF;
          end else if (rise) begin
            st  <= S_CLOSED;
            tmr <= '0;
          end else if (last_o) begin
            st  <= S_FAULT;
            tmr <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_FAULT: begin
          if (last_h) begin
            st  <= off ? S_OFF : S_CLOSED;
            tmr <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: st <= S_INIT;
      endcase
    end
  end
endmodule

// File: rtl/wdog_cal_chk.sv
`timescale 1ns/1ps
module wdog_cal_chk #(
  parameter int CNT_W = 10,
  parameter int HOLD  = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chg,
  input logic             dis,
  input logic             wdo,
  input logic             rst_req,
  input logic             rise,
  input logic             closed,
  input logic             off,
  input logic [CNT_W-1:0] cal
);
  logic flt, prev_dis, cal_done;
  int   fcnt;
  assign flt = wdo | rst_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_dis <= 1'b0;
      cal_done <= 1'b0;
      fcnt     <= 0;
    end else begin
      prev_dis <= dis;
      cal_done <= cal_done | (prev_dis & ~dis);
      fcnt     <= flt ? fcnt + 1 : 0;
    end
  end

  a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n) !(chg && dis));
  a_r1_cal_once:   assert property (@(posedge clk) disable iff (!rst_n) cal_done |-> (!chg && !dis));
  a_r2_count_mono: assert property (@(posedge clk) disable iff (!rst_n) cal >= $past(cal));
  a_r5_early:      assert property (@(posedge clk) disable iff (!rst_n) (closed && rise && !off) |=> flt);
  a_r7_hold_max:   assert property (@(posedge clk) disable iff (!rst_n) flt |-> (fcnt < HOLD));
  a_r7_hold_full:  assert property (@(posedge clk) disable iff (!rst_n) (!flt && fcnt != 0) |-> (fcnt == HOLD));
  a_r9_off_quiet:  assert property (@(posedge clk) disable iff (!rst_n) (off && !flt) |=> !flt);
  a_r10_route:     assert property (@(posedge clk) disable iff (!rst_n) $onehot0({wdo, rst_req}));
endmodule

bind wdog_cal wdog_cal_chk #(.CNT_W(CNT_W), .HOLD(HOLD)) u_chk (
  .clk(clk), .rst_n(rst_n), .chg(chg), .dis(dis), .wdo(wdo), .rst_req(rst_req),
  .rise(rise), .closed(in_closed), .off(off), .cal(cal)
);

// File: tb/test_wdog_cal.sv
`timescale 1ns/1ps
module test_wdog_cal;
  localparam int CW = 10, OM = 4, HD = 6;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, wdi = 1'b0, cmp = 1'b0;
  logic [1:0] set = 2'b00;
  logic chg, dis, wdo, rr, chg2, dis2, wdo2, rr2;

  always #5 clk = ~clk;

  wdog_cal #(.CNT_W(CW), .OPEN_MULT(OM), .HOLD(HD), .HAS_WDO(1'b1), .SET01_OFF(1'b1)) i_wdog_cal (
    .clk(clk), .rst_n(rst_n), .wdi(wdi), .set(set), .cmp(cmp),
    .chg(chg), .dis(dis), .wdo(wdo), .rst_req(rr));
  wdog_cal #(.CNT_W(CW), .OPEN_MULT(OM), .HOLD(HD), .HAS_WDO(1'b0), .SET01_OFF(1'b1)) i_wdog_cal_r (
    .clk(clk), .rst_n(rst_n), .wdi(wdi), .set(set), .cmp(cmp),
    .chg(chg2), .dis(dis2), .wdo(wdo2), .rst_req(rr2));

  int cyc = 0, checks = 0, fails = 0, fs = 0, cal = 0;
  int r1_bad = 0, r10_bad = 0;
  bit running = 1'b0;
  int unsigned seed_init;

  function automatic int exp_close(int c, logic [1:0] s);
    if (s == 2'b11) return c;
    if (s == 2'b10) return 4 * c;
    return 8 * c;
  endfunction
  function automatic int exp_open(int c);
    return OM * c;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (rr !== 1'b0 || wdo2 !== 1'b0 || rr2 !== wdo) r10_bad++;
    if (running && (chg || dis)) r1_bad++;
  endtask

  task automatic run_clean(int t, string tag);
    int bad = 0;
    while (cyc < t) begin
      if (wdo) bad++;
      step();
    end
    chk(bad == 0, tag, bad, 0);
  endtask

  task automatic fault_seq(string tag);
    int hi = 0;
    for (int i = 0; i < HD; i++) begin
      if (wdo) hi++;
      step();
    end
    chk(hi == HD && !wdo, tag, hi, HD);
    fs = cyc;
  endtask

  task automatic calibrate(int kc, int kd);
    int c = 0, d = 0, g = 0;
    running = 1'b0;
    cmp = 1'b0; wdi = 1'b0; rst_n = 1'b0;
    repeat (3) step();
    chk(!chg && !dis && !wdo && !rr && !rr2, "R11 outputs low in reset", {chg, dis, wdo, rr}, 0);
    rst_n = 1'b1;
    while (!chg && g < 10) begin step(); g++; end
    while ((chg || dis) && g < 5000) begin
      if (chg) c++;
      if (dis) d++;
      if (chg && c == kc) cmp = 1'b1;
      if (dis && d == kd) cmp = 1'b0;
      step(); g++;
    end
    chk(c == kc && d == kd, "R1 one charge then one discharge", c * 10000 + d, kc * 10000 + kd);
    cal = (kc + kd > CMAX) ? CMAX : kc + kd;
    fs = cyc;
    running = 1'b1;
  endtask

  task automatic kick(int n0, int w, string tag);
    run_clean(n0, tag);
    wdi = 1'b1;
    repeat (w) step();
    wdi = 1'b0;
  endtask

  task automatic valid_frame(int off, int w, string tag);
    int n0 = fs + off;
    kick(n0, w, tag);
    fs = n0 + 3;
  endtask

  task automatic early_frame(int off, int w, string tag);
    int n0 = fs + off;
    kick(n0, w, tag);
    run_clean(n0 + 3, tag);
    chk(wdo == 1'b1, tag, wdo, 1);
    fault_seq("R7 fault hold length");
  endtask

  task automatic late_frame(string tag);
    run_clean(fs + exp_close(cal, set) + exp_open(cal), tag);
    chk(wdo == 1'b1, tag, wdo, 1);
    fault_seq("R7 fault hold length");
  endtask

  task automatic random_frames(int n);
    for (int i = 0; i < n; i++) begin
      int lc = exp_close(cal, set), lo = exp_open(cal);
      int kind = $urandom_range(0, 2);
      int w = $urandom_range(1, 2);
      if (kind == 0) valid_frame($urandom_range(lc - 2, lc + lo - 3), w, "R4 kick in open window");
      else if (kind == 1) early_frame($urandom_range(0, lc - 3), w, "R5 early kick fault");
      else late_frame("R6 missing kick fault");
    end
  endtask

  initial begin
    seed_init = $urandom(32'd90210);
    set = 2'b00;
    calibrate(3, 4);
    valid_frame(exp_close(cal, set) - 2, 1, "R3 first open cycle kick code 00");
    early_frame(exp_close(cal, set) - 3, 1, "R3 last closed cycle is early code 00");
    valid_frame(exp_close(cal, set) + exp_open(cal) - 3, 2, "R4 last open cycle kick");
    late_frame("R6 late fault code 00");
    random_frames(12);

    for (int r = 0; r < 3; r++) begin
      set = (r == 0) ? 2'b10 : (r == 1) ? 2'b11 : 2'b01;
      calibrate($urandom_range(2, 8), $urandom_range(2, 8));
      if (set == 2'b01) begin
        int bad = 0;
        for (int i = 0; i < 300; i++) begin
          wdi = (i % 7 == 3);
          if (wdo) bad++;
          step();
        end
        wdi = 1'b0;
        repeat (5) step();
        chk(bad == 0, "R9 code 01 disables supervision", bad, 0);
        set = 2'b00;
        fs = cyc + 1;
        step();
        late_frame("R9 fresh closed window after enable");
        valid_frame(exp_close(cal, set) - 2, 1, "R3 code 01 not used, 00 full window");
      end else begin
        valid_frame(exp_close(cal, set) - 2, 1, "R3 first open cycle kick");
        early_frame(exp_close(cal, set) - 3, 1, "R3 last closed cycle is early");
        late_frame("R6 late fault");
      end
      random_frames(12);
    end

    // R7/R8: rising edge during fault is ignored, its falling edge lands in closed window
    set = 2'b10;
    calibrate(5, 3);
    run_clean(fs + exp_close(cal, set) + exp_open(cal), "R6 late fault before hold test");
    chk(wdo == 1'b1, "R6 late fault", wdo, 1);
    wdi = 1'b1;
    fault_seq("R7 edge during fault ignored");
    step();
    wdi = 1'b0;
    late_frame("R8 falling edge in closed window ignored");

    // R2: saturation, R11: recalibration replaces the count
    set = 2'b11;
    calibrate(1100, 10);
    late_frame("R2 saturated count sets window");
    calibrate(2, 2);
    valid_frame(exp_close(cal, set) - 2, 1, "R11 new count after reset");
    early_frame(exp_close(cal, set) - 3, 1, "R11 new count after reset early edge");

    running = 1'b0;
    chk(r1_bad == 0, "R1 no element drive after calibration", r1_bad, 0);
    chk(r10_bad == 0, "R10 fault routed to selected output", r10_bad, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(150000 * 10);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule